// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block holds the digital control and status logic that sits beside a successive-approximation converter. It walks a programmable list of one to eight channels, starting at channel 0. It hands each channel number to the converter and collects the 10-bit code that comes back. Each code is stored per channel, and completion and overrun flags are kept alongside.

A sequence starts in one of two ways:
- Software writes the control register with the start bit set.
- When external triggering is armed, a rising edge on a trigger pin starts it.

The block then either stops after one pass or loops without end. Software reads a result register and gets the stored code in one of several formats: 8 or 10 bits, right- or left-justified, unsigned or two's complement.

The converter link uses two streams. On the request stream, the block offers a channel number with `req_valid`, and the converter takes it with `req_ready`. The block holds `req_valid` and `req_chan` steady until the request is accepted; back-pressure on this stream just stalls the sequence. On the result stream, the converter offers a code with `res_valid`, and the block accepts it only while `res_ready` is high. A code offered while `res_ready` is low is not taken, and the converter must drop it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the status register (address 1) reads 0, `req_valid` is 0 and `seq_irq` is 0.
- R2: A control write (address 0) with start bit 15 set and external-trigger bit 4 clear requests channels 0, 1, ... up to the length field (bits 2:0 hold length minus 1) in order. Each request stays valid, with its channel stable, until accepted, and the channel never exceeds the length field.
- R3: With scan bit 3 clear, the sequence stops after the last channel and sets the done flag (status bit 0). Every new sequence sets it again.
- R4: With scan bit 3 set, the channel number wraps to 0 and conversion continues. The done flag is set at the end of the first pass only.
- R5: Storing a channel's result sets its completion bit (status bit 8+channel). Reading that channel's result register (address 8+channel) clears the bit.
- R6: Storing a result while that channel's completion bit is set raises the overwrite flag (status bit 2). Writing 1 to status bit 2 clears it.
- R7: With bit 4 set, a rising trigger edge while idle starts a sequence. An edge during a sequence sets the trigger-overrun flag (status bit 1) and does not restart it. Writing 1 to status bit 1 clears that flag.
- R8: With fast-clear bit 5 clear, any status write clears the done flag, and result reads leave it alone.
- R9: With bit 5 set, a result read clears the done flag and status writes leave it alone.
- R10: Result reads are formatted as follows:
  - Bit 7 selects the upper 8 code bits instead of all 10.
  - Bit 9 inverts the MSB and sign-extends (two's complement).
  - Bit 8 left-justifies into 16 bits, with the low bits zero.
- R11: Any control write aborts a running sequence and resets the channel counter (status bits 5:3) to 0. It starts again only if the write itself requests a start.
- R12: `seq_irq` is high exactly while the done flag is set and interrupt-enable bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (result read side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| trig_in | input | 1 | External start trigger, rising edge active |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts request |
| req_chan | output | 3 | Channel to convert |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Block accepts result |
| res_code | input | 10 | Converter code |
| seq_irq | output | 1 | Sequence-complete interrupt request |

## Verification
Read data is combinational, so the bench samples `reg_rdata` 1 ns after driving the address on a falling edge. Flags set by an accepted result become visible one clock after the rising edge that takes `res_valid`. Clears from a status write or result read land on the edge that samples the strobe, and the bench looks at the following falling edge. After a control write, the first request or the reset counter shows one edge later. The bench therefore waits fixed, generous cycle counts for a sequence to drain, pauses the modelled converter before it probes mid-sequence state, and checks the request log only once activity has stopped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // control register bit positions
  localparam int CB_SCAN  = 3;
  localparam int CB_EXT   = 4;
  localparam int CB_FAST  = 5;
  localparam int CB_IRQ   = 6;
  localparam int CB_RES8  = 7;
  localparam int CB_LEFT  = 8;
  localparam int CB_SGN   = 9;
  localparam int CB_START = 15;
  // status register bit positions
  localparam int SB_DONE  = 0;
  localparam int SB_TOVR  = 1;
  localparam int SB_OVW   = 2;
  localparam int SB_CNT   = 3;
  localparam int SB_CCF   = 8;
  // register addresses (results live where the top address bit is set)
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_STAT = 4'h1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} sq_state_e;
endpackage

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            sw_start,
  input  logic            ext_en,
  input  logic            scan,
  input  logic [CH_W-1:0] len_m1,
  input  logic            trig_in,
  input  logic            req_ready,
  input  logic            res_valid,
  output logic            req_valid,
  output logic            res_ready,
  output logic [CH_W-1:0] cur_ch,
  output logic            store,
  output logic            done_set,
  output logic            trig_ovr,
  output logic            busy
);
  sq_state_e       state_q;
  logic [CH_W-1:0] cc_q;
  logic            first_q;
  logic            trig_q;
  logic            trig_edge;
  logic            last_ch;

  assign trig_edge = trig_in & ~trig_q;
  assign req_valid = (state_q == SQ_REQ);
  assign res_ready = (state_q == SQ_WAIT) & ~abort;
  assign store     = res_valid & res_ready;
  assign last_ch   = (cc_q == len_m1);
  assign done_set  = store & last_ch & first_q;
  assign busy      = (state_q != SQ_IDLE);
  assign trig_ovr  = ext_en & trig_edge & busy & ~abort;
  assign cur_ch    = cc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cc_q    <= '0;
      first_q <= 1'b1;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (abort) begin
        cc_q    <= '0;
        first_q <= 1'b1;
        state_q <= sw_start ? SQ_REQ : SQ_IDLE;
      end else begin
        case (state_q)
          SQ_IDLE: if (ext_en && trig_edge) begin
            cc_q    <= '0;
            first_q <= 1'b1;
            state_q <= SQ_REQ;
          end
          SQ_REQ: if (req_ready) state_q <= SQ_WAIT;
          SQ_WAIT: if (store) begin
            if (last_ch) begin
              cc_q    <= '0;
              first_q <= 1'b0;
              state_q <= scan ? SQ_REQ : SQ_IDLE;
            end else begin
              cc_q    <= cc_q + 1'b1;
              state_q <= SQ_REQ;
            end
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_res_bank.sv
module adc_res_bank #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           store,
  input  logic [CH_W-1:0]                ch,
  input  logic [CODE_W-1:0]              code,
  input  logic [NUM_CH-1:0]              rd_clr,
  output logic [NUM_CH-1:0]              ccf,
  output logic [NUM_CH-1:0][CODE_W-1:0]  raw,
  output logic                           ovw
);
  assign ovw = store & ccf[ch] & ~rd_clr[ch];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ccf[g] <= 1'b0;
        raw[g] <= '0;
      end else if (store && ch == CH_W'(g)) begin
        ccf[g] <= 1'b1;
        raw[g] <= code;
      end else if (rd_clr[g]) begin
        ccf[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
  parameter int CODE_W   = 10,
  parameter int NARROW_W = 8,
  parameter int DATA_W   = 16
) (
  input  logic [CODE_W-1:0] code,
  input  logic              res8,
  input  logic              left,
  input  logic              sgn,
  output logic [DATA_W-1:0] data
);
  logic [CODE_W-1:0]   wide;
  logic [NARROW_W-1:0] narrow;

  always_comb begin
    wide   = code;
    narrow = code[CODE_W-1 -: NARROW_W];
    if (sgn) begin
      wide[CODE_W-1]     = ~wide[CODE_W-1];
      narrow[NARROW_W-1] = ~narrow[NARROW_W-1];
    end
    if (res8) begin
      if (left) data = {narrow, {(DATA_W-NARROW_W){1'b0}}};
      else      data = {{(DATA_W-NARROW_W){sgn & narrow[NARROW_W-1]}}, narrow};
    end else begin
      if (left) data = {wide, {(DATA_W-CODE_W){1'b0}}};
      else      data = {{(DATA_W-CODE_W){sgn & wide[CODE_W-1]}}, wide};
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              trig_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CH_W-1:0]   req_chan,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CODE_W-1:0] res_code,
  output logic              seq_irq
);
  logic [DATA_W-1:0]             ctrl_q;
  logic                          seq_done_q, trig_ovr_q, ovw_q;
  logic                          ctrl_wr, stat_wr, res_sel, res_rd;
  logic [CH_W-1:0]               rd_ch;
  logic [NUM_CH-1:0]             rd_clr, ccf;
  logic [NUM_CH-1:0][CODE_W-1:0] raw;
  logic                          store, done_set, tovr_set, ovw_set, busy;
  logic [DATA_W-1:0]             fmt_data, stat_word;
  logic                          fast;

  assign ctrl_wr = reg_wr & (reg_addr == ADDR_W'(A_CTRL));
  assign stat_wr = reg_wr & (reg_addr == ADDR_W'(A_STAT));
  assign res_sel = reg_addr[ADDR_W-1];
  assign rd_ch   = reg_addr[CH_W-1:0];
  assign res_rd  = reg_rd & res_sel;
  assign rd_clr  = res_rd ? (NUM_CH'(1) << rd_ch) : '0;
  assign fast    = ctrl_q[CB_FAST];

  adc_seq_engine #(.CH_W(CH_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(ctrl_wr),
    .sw_start(reg_wdata[CB_START] & ~reg_wdata[CB_EXT]),
    .ext_en(ctrl_q[CB_EXT]), .scan(ctrl_q[CB_SCAN]), .len_m1(ctrl_q[CH_W-1:0]),
    .trig_in(trig_in), .req_ready(req_ready), .res_valid(res_valid),
    .req_valid(req_valid), .res_ready(res_ready), .cur_ch(req_chan),
    .store(store), .done_set(done_set), .trig_ovr(tovr_set), .busy(busy)
  );

  adc_res_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .store(store), .ch(req_chan), .code(res_code),
    .rd_clr(rd_clr), .ccf(ccf), .raw(raw), .ovw(ovw_set)
  );

  adc_res_fmt #(.CODE_W(CODE_W), .NARROW_W(8), .DATA_W(DATA_W)) u_fmt (
    .code(raw[rd_ch]), .res8(ctrl_q[CB_RES8]), .left(ctrl_q[CB_LEFT]),
    .sgn(ctrl_q[CB_SGN]), .data(fmt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      seq_done_q <= 1'b0;
      trig_ovr_q <= 1'b0;
      ovw_q      <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q           <= reg_wdata;
        ctrl_q[CB_START] <= 1'b0;
      end
      if (done_set)                                     seq_done_q <= 1'b1;
      else if ((stat_wr && !fast) || (res_rd && fast))  seq_done_q <= 1'b0;
      if (tovr_set)                                     trig_ovr_q <= 1'b1;
      else if (stat_wr && reg_wdata[SB_TOVR])           trig_ovr_q <= 1'b0;
      if (ovw_set)                                      ovw_q      <= 1'b1;
      else if (stat_wr && reg_wdata[SB_OVW])            ovw_q      <= 1'b0;
    end
  end

  always_comb begin
    stat_word                       = '0;
    stat_word[SB_DONE]              = seq_done_q;
    stat_word[SB_TOVR]              = trig_ovr_q;
    stat_word[SB_OVW]               = ovw_q;
    stat_word[SB_CNT +: CH_W]       = req_chan;
    stat_word[SB_CCF +: NUM_CH]     = ccf;
  end

  always_comb begin
    if (res_sel)                              reg_rdata = fmt_data;
    else if (reg_addr == ADDR_W'(A_CTRL))     reg_rdata = ctrl_q;
    else if (reg_addr == ADDR_W'(A_STAT))     reg_rdata = stat_word;
    else                                      reg_rdata = '0;
  end

  assign seq_irq = seq_done_q & ctrl_q[CB_IRQ];
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CH_W-1:0]   req_chan,
  input logic              res_valid,
  input logic              res_ready,
  input logic [CH_W-1:0]   len_m1,
  input logic [NUM_CH-1:0] ccf,
  input logic              ext_en,
  input logic              trig_in,
  input logic              busy,
  input logic              trig_ovr_q,
  input logic              seq_done_q,
  input logic              seq_irq
);
  logic            trig_d, ctrl_wr;
  logic [CH_W-1:0] last_ch;

  assign ctrl_wr = reg_wr && (reg_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_d  <= 1'b0;
      last_ch <= '0;
    end else begin
      trig_d  <= trig_in;
      last_ch <= req_chan;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !ctrl_wr |=> req_valid && $stable(req_chan));
  // R2
  req_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_chan <= len_m1);
  // R2
  req_res_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && res_ready));
  // R5
  ccf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> ccf[last_ch]);
  // R7
  trig_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en && trig_in && !trig_d && busy && !ctrl_wr |=> trig_ovr_q);
  // R12
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_irq |-> seq_done_q);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
  .res_valid(res_valid), .res_ready(res_ready), .len_m1(ctrl_q[CH_W-1:0]),
  .ccf(ccf), .ext_en(ctrl_q[4]), .trig_in(trig_in), .busy(busy),
  .trig_ovr_q(trig_ovr_q), .seq_done_q(seq_done_q), .seq_irq(seq_irq)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  import adc_seq_pkg::*;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0, trig_in = 0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        req_valid, req_ready = 0, res_valid = 0, res_ready, seq_irq;
  logic [2:0]  req_chan;
  logic [9:0]  res_code = '0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig_in(trig_in), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .seq_irq(seq_irq)
  );

  int         n_chk = 0, n_bad = 0, nlog = 0, lat = 3;
  int         log_ch [256];
  logic [9:0] codes [8];
  bit         conv_en = 1'b1, finished = 1'b0;

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (conv_en && req_valid) begin
        automatic int ch = int'(req_chan);
        if (nlog < 256) log_ch[nlog] = ch;
        nlog++;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        if (res_ready) begin
          res_code  = codes[ch];
          res_valid = 1'b1;
          @(negedge clk);
          res_valid = 1'b0;
        end
      end
    end
  end

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(int len_m1, bit scan, bit ext, bit fast,
                                      bit irq, bit r8, bit lft, bit sg, bit st);
    logic [15:0] v = '0;
    v[2:0] = 3'(len_m1);
    v[CB_SCAN] = scan; v[CB_EXT] = ext; v[CB_FAST] = fast; v[CB_IRQ] = irq;
    v[CB_RES8] = r8; v[CB_LEFT] = lft; v[CB_SGN] = sg; v[CB_START] = st;
    return v;
  endfunction

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    wr(A_CTRL, 16'h0000);
    for (int c = 0; c < 8; c++) rd(4'(8 + c), d);
    wr(A_STAT, 16'h0006);
  endtask

  task automatic t_reset();
    logic [15:0] s;
    peek(A_STAT, s);
    check("R1 status", int'(s), 0);
    check("R1 req_valid", int'(req_valid), 0);
    check("R1 irq", int'(seq_irq), 0);
  endtask

  task automatic t_single();
    logic [15:0] s, d;
    int n0 = nlog;
    wr(A_CTRL, ctl(3, 0, 0, 0, 0, 0, 0, 0, 1));
    repeat (80) @(negedge clk);
    check("R2 request count", nlog - n0, 4);
    for (int i = 0; i < 4; i++) check("R2 channel order", log_ch[n0 + i], i);
    peek(A_STAT, s);
    check("R3 done set", int'(s[SB_DONE]), 1);
    check("R5 ccf set", int'(s[15:8]), 'h0F);
    rd(4'(10), d);
    check("R10 10-bit unsigned right", int'(d), int'(codes[2]));
    peek(A_STAT, s);
    check("R5 ccf cleared by read", int'(s[15:8]), 'h0B);
    check("R8 read keeps done", int'(s[SB_DONE]), 1);
    wr(A_STAT, 16'h0000);
    peek(A_STAT, s);
    check("R8 status write clears done", int'(s[SB_DONE]), 0);
  endtask

  task automatic t_overwrite();
    logic [15:0] s;
    wr(A_CTRL, ctl(3, 0, 0, 0, 0, 0, 0, 0, 1));
    repeat (80) @(negedge clk);
    peek(A_STAT, s);
    check("R6 overwrite set", int'(s[SB_OVW]), 1);
    check("R3 done set again", int'(s[SB_DONE]), 1);
    wr(A_STAT, 16'h0004);
    peek(A_STAT, s);
    check("R6 overwrite cleared", int'(s[SB_OVW]), 0);
    clear_all();
  endtask

  task automatic t_scan();
    logic [15:0] s;
    int n0 = nlog, n1;
    wr(A_CTRL, ctl(2, 1, 0, 0, 1, 0, 0, 0, 1));
    repeat (60) @(negedge clk);
    for (int i = 0; i < 6; i++) check("R4 wrap order", log_ch[n0 + i], i % 3);
    peek(A_STAT, s);
    check("R4 done after first pass", int'(s[SB_DONE]), 1);
    check("R12 irq high", int'(seq_irq), 1);
    wr(A_STAT, 16'h0000);
    #1 check("R12 irq low", int'(seq_irq), 0);
    n1 = nlog;
    repeat (60) @(negedge clk);
    peek(A_STAT, s);
    check("R4 done not set on later passes", int'(s[SB_DONE]), 0);
    check("R4 continues", int'(nlog - n1 >= 6), 1);
    clear_all();
  endtask

  task automatic t_abort();
    logic [15:0] s;
    int n0 = nlog, guard = 0;
    wr(A_CTRL, ctl(7, 0, 0, 0, 0, 0, 0, 0, 1));
    while (nlog - n0 < 5 && guard < 200) begin
      @(negedge clk); #1 guard++;
    end
    conv_en = 1'b0;
    repeat (20) @(negedge clk);
    peek(A_STAT, s);
    check("R11 counter mid-sequence", int'(s[5:3]), 5);
    wr(A_CTRL, ctl(7, 0, 0, 0, 0, 0, 0, 0, 1));
    peek(A_STAT, s);
    check("R11 counter reset", int'(s[5:3]), 0);
    check("R11 restart channel", int'(req_chan), 0);
    wr(A_CTRL, ctl(7, 0, 0, 0, 0, 0, 0, 0, 0));
    n0 = nlog;
    conv_en = 1'b1;
    repeat (30) @(negedge clk);
    check("R11 stop without start", nlog - n0, 0);
    check("R11 req_valid low", int'(req_valid), 0);
    clear_all();
  endtask

  task automatic t_ext();
    logic [15:0] s;
    int n0;
    lat = 6;
    wr(A_CTRL, ctl(1, 0, 1, 0, 0, 0, 0, 0, 0));
    n0 = nlog;
    pulse_trig();
    repeat (4) @(negedge clk);
    pulse_trig();
    repeat (60) @(negedge clk);
    check("R7 no restart", nlog - n0, 2);
    peek(A_STAT, s);
    check("R7 overrun flag", int'(s[SB_TOVR]), 1);
    pulse_trig();
    repeat (60) @(negedge clk);
    check("R7 idle edge starts", nlog - n0, 4);
    wr(A_STAT, 16'h0002);
    peek(A_STAT, s);
    check("R7 overrun cleared", int'(s[SB_TOVR]), 0);
    lat = 3;
    clear_all();
  endtask

  task automatic t_fast();
    logic [15:0] s, d;
    wr(A_CTRL, ctl(0, 0, 0, 1, 0, 0, 0, 0, 1));
    repeat (30) @(negedge clk);
    wr(A_STAT, 16'h0000);
    peek(A_STAT, s);
    check("R9 status write ignored", int'(s[SB_DONE]), 1);
    rd(4'(8), d);
    peek(A_STAT, s);
    check("R9 read clears done", int'(s[SB_DONE]), 0);
    check("R9 read clears ccf", int'(s[SB_CCF]), 0);
    clear_all();
  endtask

  task automatic fmt_case(logic [3:0] a, bit r8, bit lft, bit sg, int exp, string rq);
    logic [15:0] d;
    wr(A_CTRL, ctl(1, 0, 0, 0, 0, r8, lft, sg, 0));
    rd(a, d);
    check(rq, int'(d), exp);
  endtask

  task automatic t_fmt();
    wr(A_CTRL, ctl(1, 0, 0, 0, 0, 0, 0, 0, 1));
    repeat (40) @(negedge clk);
    fmt_case(4'(8), 0, 0, 0, 'h02A5, "R10 10u right");
    fmt_case(4'(8), 0, 1, 0, 'hA940, "R10 10u left");
    fmt_case(4'(8), 0, 0, 1, 'h00A5, "R10 10s right pos");
    fmt_case(4'(8), 0, 1, 1, 'h2940, "R10 10s left");
    fmt_case(4'(9), 0, 0, 1, 'hFEA5, "R10 10s right neg");
    fmt_case(4'(8), 1, 0, 0, 'h00A9, "R10 8u right");
    fmt_case(4'(8), 1, 1, 0, 'hA900, "R10 8u left");
    fmt_case(4'(8), 1, 0, 1, 'h0029, "R10 8s right pos");
    fmt_case(4'(9), 1, 0, 1, 'hFFA9, "R10 8s right neg");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) codes[i] = 10'(i * 83 + 17);
    codes[0] = 10'h2A5;
    codes[1] = 10'h0A5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_overwrite();
    t_scan();
    t_abort();
    t_ext();
    t_fast();
    t_fmt();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule